// File: doc/BRIEF.md
# 24-bit Add/Subtract Execute Unit with NZVC Flags

This unit is the execute step for the arithmetic instruction group of a small 24-bit processor. A decoder in front of it hands over the major opcode, the 4-bit sub-opcode and the operand values. The operands are the first source register, the second source register, the current destination register value, an 8-bit immediate and a 12-bit immediate. The unit also takes the current condition flags. It returns a 24-bit result for the destination register, a result write-enable, the next value of the flags and a flag write-enable.

The sub-opcode selects one of three operand shapes. In the register shape, source 1 is combined with source 2. In the long-immediate shape, the destination register is combined with the 12-bit immediate. In the short-immediate shape, source 1 is combined with the 8-bit immediate. The same sub-opcode also selects add or subtract, selects whether the carry flag is fed in, and selects signed or unsigned widening of the immediate. Only the register shape produces new flags. Every other instruction hands the incoming flags straight back, so the flag register can be written back unconditionally if the integrator prefers.

The arithmetic is combinational. A parameter adds one output register stage, which is present by default. That stage has an asynchronous active-low reset.

Top module: `alu24_exec`

## Requirements
- R1: Only major opcode 4 is the arithmetic group. Any other major opcode drives both write-enables low and returns the incoming flags unchanged. The result output still carries the arithmetic value selected by the sub-opcode.
- R2: Sub-opcode 0 returns src1 + src2 and sub-opcode 4 returns src1 - src2, modulo 2^24. Both assert both write-enables.
- R3: Sub-opcode 8 returns src1 + src2 + C and sub-opcode 12 returns src1 - src2 - C. Here C is bit 0 of the incoming flags.
- R4: Sub-opcodes 1, 5, 9 and 13 give the same result, flags and enables as 0, 4, 8 and 12 respectively.
- R5: Sub-opcodes 2 and 10 return dest + imm12, and sub-opcodes 6 and 14 return dest - imm12. Sub-opcodes 2 and 6 sign-extend the immediate; 10 and 14 zero-extend it.
- R6: Sub-opcodes 3 and 11 return src1 + imm8, and sub-opcodes 7 and 15 return src1 - imm8. Sub-opcodes 3 and 7 sign-extend the immediate; 11 and 15 zero-extend it.
- R7: The flags are packed as bit 3 N, bit 2 Z, bit 1 V and bit 0 C. On a flag-writing operation, Z is 1 exactly when the 24-bit result is zero, and N equals result bit 23.
- R8: On a flag-writing add, C is the carry out of bit 23. On a flag-writing subtract, C is 1 when src1 < src2 + carry-in as unsigned numbers, so C means borrow.
- R9: V is the signed overflow of src1 ± src2 computed with a carry-in of zero, even for the carry forms.
- R10: Every immediate form holds the flag write-enable low and returns the incoming flags unchanged, including when the result is zero or negative.
- R11: With the output stage present, the outputs show each input set one clock later. Reset drives the result, the flags and both enables to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| major_op | input | 4 | Major opcode of the instruction |
| sub_op | input | 4 | Sub-opcode selecting the operation |
| src1_val | input | 24 | First source register value |
| src2_val | input | 24 | Second source register value |
| dest_val | input | 24 | Current destination register value |
| imm8 | input | 8 | Short immediate |
| imm12 | input | 12 | Long immediate |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| result | output | 24 | Value for the destination register |
| res_we | output | 1 | Destination write-enable |
| flags_out | output | 4 | Next flags {N,Z,V,C} |
| flag_we | output | 1 | Flag write-enable |

## Verification
The carry forms are checked with operands chosen so that V with the carry folded in would differ from V without it. A design that fed the carry into the overflow test would report overflow on 0x7FFFFF + 0 + 1. Subtract borrow is checked at the case where the carry-in alone turns equality into a borrow. That catches a design that compares only src1 < src2. Immediate vectors use set flag inputs and results of zero or with bit 23 set, so a design that updated flags on immediates, or widened an immediate with the wrong sign rule, or took the wrong base register, changes a visible value. The alternative sub-opcodes are compared against the same vectors as their primaries. Separate checks cover the one-cycle output latency and the asynchronous reset.

// File: rtl/alu24_pkg.sv
package alu24_pkg;

    // Width of the packed flag vector {N,Z,V,C}
    localparam int FLAG_W = 4;
    localparam int FLG_N  = 3;
    localparam int FLG_Z  = 2;
    localparam int FLG_V  = 1;
    localparam int FLG_C  = 0;

    // Operand shape chosen by the sub-opcode
    typedef enum logic [1:0] {
        SHAPE_REG   = 2'd0,
        SHAPE_LONG  = 2'd1,
        SHAPE_SHORT = 2'd2
    } shape_e;

    typedef struct packed {
        logic   subtract;
        logic   use_cin;
        logic   imm_signed;
        shape_e shape;
    } alu_ctrl_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

endpackage

// File: rtl/alu24_opdec.sv
module alu24_opdec
    import alu24_pkg::*;
#(
    parameter int SUB_W = 4
) (
    input  logic [SUB_W-1:0] sub_op,
    output alu_ctrl_t        ctrl
);

    // Sub-opcode bits: [3] carry / unsigned, [2] subtract, [1:0] shape
    always_comb begin
        ctrl.subtract   = sub_op[2];
        ctrl.use_cin    = sub_op[3] & ~sub_op[1];
        ctrl.imm_signed = ~sub_op[3];
        unique case (sub_op[1:0])
            2'b00, 2'b01: ctrl.shape = SHAPE_REG;
            2'b10:        ctrl.shape = SHAPE_LONG;
            default:      ctrl.shape = SHAPE_SHORT;
        endcase
    end

endmodule

// File: rtl/alu24_opsel.sv
module alu24_opsel
    import alu24_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int SHORT_W = 8,
    parameter int LONG_W = 12
) (
    input  shape_e            shape,
    input  logic              imm_signed,
    input  logic [DATA_W-1:0] src1_val,
    input  logic [DATA_W-1:0] src2_val,
    input  logic [DATA_W-1:0] dest_val,
    input  logic [SHORT_W-1:0] imm8,
    input  logic [LONG_W-1:0] imm12,
    output logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] opb
);

    localparam int SHORT_PAD = DATA_W - SHORT_W;
    localparam int LONG_PAD  = DATA_W - LONG_W;

    logic [DATA_W-1:0] short_ext;
    logic [DATA_W-1:0] long_ext;

    always_comb begin
        short_ext = {{SHORT_PAD{imm_signed & imm8[SHORT_W-1]}}, imm8};
        long_ext  = {{LONG_PAD{imm_signed & imm12[LONG_W-1]}}, imm12};
        unique case (shape)
            SHAPE_LONG: begin
                opa = dest_val;
                opb = long_ext;
            end
            SHAPE_SHORT: begin
                opa = src1_val;
                opb = short_ext;
            end
            default: begin
                opa = src1_val;
                opb = src2_val;
            end
        endcase
    end

endmodule

// File: rtl/alu24_addsub.sv
module alu24_addsub
    import alu24_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              cin,
    input  logic              subtract,
    output logic [DATA_W-1:0] sum,
    output nzvc_t             flags
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0]   wide;
    logic [DATA_W-1:0] plain;

    always_comb begin
        if (subtract) begin
            wide  = {1'b0, opa} - {1'b0, opb} - {{DATA_W{1'b0}}, cin};
            plain = opa - opb;
        end else begin
            wide  = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, cin};
            plain = opa + opb;
        end
        sum     = wide[DATA_W-1:0];
        flags.n = wide[MSB];
        flags.z = (wide[DATA_W-1:0] == '0);
        // Bit DATA_W is carry for add and borrow for subtract
        flags.c = wide[DATA_W];
        // Overflow ignores the carry-in
        if (subtract)
            flags.v = (opa[MSB] != opb[MSB]) && (plain[MSB] != opa[MSB]);
        else
            flags.v = (opa[MSB] == opb[MSB]) && (plain[MSB] != opa[MSB]);
    end

endmodule

// File: rtl/alu24_exec.sv
module alu24_exec
    import alu24_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int MAJ_W       = 4,
    parameter int SUB_W       = 4,
    parameter int SHORT_W     = 8,
    parameter int LONG_W      = 12,
    parameter int ARITH_MAJOR = 4,
    parameter bit OUT_REG     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAJ_W-1:0]  major_op,
    input  logic [SUB_W-1:0]  sub_op,
    input  logic [DATA_W-1:0] src1_val,
    input  logic [DATA_W-1:0] src2_val,
    input  logic [DATA_W-1:0] dest_val,
    input  logic [SHORT_W-1:0] imm8,
    input  logic [LONG_W-1:0] imm12,
    input  logic [3:0]        flags_in,
    output logic [DATA_W-1:0] result,
    output logic              res_we,
    output logic [3:0]        flags_out,
    output logic              flag_we
);

    localparam logic [MAJ_W-1:0] ARITH_CODE = MAJ_W'(ARITH_MAJOR);

    alu_ctrl_t         ctrl;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] res_c;
    nzvc_t             new_flags;
    logic              arith_hit;
    logic              cin_eff;
    logic              rwe_c;
    logic              fwe_c;
    logic [FLAG_W-1:0] flags_c;

    alu24_opdec #(.SUB_W(SUB_W)) u_dec (
        .sub_op (sub_op),
        .ctrl   (ctrl)
    );

    alu24_opsel #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_sel (
        .shape      (ctrl.shape),
        .imm_signed (ctrl.imm_signed),
        .src1_val   (src1_val),
        .src2_val   (src2_val),
        .dest_val   (dest_val),
        .imm8       (imm8),
        .imm12      (imm12),
        .opa        (opa),
        .opb        (opb)
    );

    assign cin_eff = ctrl.use_cin & flags_in[FLG_C];

    alu24_addsub #(.DATA_W(DATA_W)) u_as (
        .opa      (opa),
        .opb      (opb),
        .cin      (cin_eff),
        .subtract (ctrl.subtract),
        .sum      (res_c),
        .flags    (new_flags)
    );

    always_comb begin
        arith_hit = (major_op == ARITH_CODE);
        rwe_c     = arith_hit;
        fwe_c     = arith_hit && (ctrl.shape == SHAPE_REG);
        flags_c   = fwe_c ? FLAG_W'(new_flags) : flags_in;
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    result    <= '0;
                    res_we    <= 1'b0;
                    flags_out <= '0;
                    flag_we   <= 1'b0;
                end else begin
                    result    <= res_c;
                    res_we    <= rwe_c;
                    flags_out <= flags_c;
                    flag_we   <= fwe_c;
                end
            end

            // R11
            out_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rwe_c |=> res_we);
        end else begin : g_comb
            always_comb begin
                result    = res_c;
                res_we    = rwe_c;
                flags_out = flags_c;
                flag_we   = fwe_c;
            end
        end
    endgenerate

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwe_c |-> (flags_c[FLG_Z] == (res_c == '0)));

    // R7
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwe_c |-> (flags_c[FLG_N] == res_c[DATA_W-1]));

    // R10
    imm_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arith_hit && ctrl.shape != SHAPE_REG) |-> (!fwe_c && flags_c == flags_in));

    // R1
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arith_hit |-> (!rwe_c && !fwe_c && flags_c == flags_in));

endmodule

// File: tb/alu24_exec_bench.sv
module alu24_exec_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 23;

    typedef struct packed {
        logic [3:0]  maj;
        logic [3:0]  sub;
        logic [23:0] s1;
        logic [23:0] s2;
        logic [23:0] dst;
        logic [7:0]  i8;
        logic [11:0] i12;
        logic [3:0]  fin;
        logic [23:0] eres;
        logic [3:0]  eflg;
        logic        ewe;
        logic        efwe;
    } vec_t;

    // Flags are {N,Z,V,C}
    localparam vec_t VECS [NV] = '{
        '{4'h4, 4'h0, 24'h000005, 24'h000003, 24'h0, 8'h0, 12'h0, 4'h0, 24'h000008, 4'h0, 1'b1, 1'b1},
        '{4'h4, 4'h0, 24'hFFFFFF, 24'h000001, 24'h0, 8'h0, 12'h0, 4'h0, 24'h000000, 4'h5, 1'b1, 1'b1},
        '{4'h4, 4'h0, 24'h7FFFFF, 24'h000001, 24'h0, 8'h0, 12'h0, 4'h0, 24'h800000, 4'hA, 1'b1, 1'b1},
        '{4'h4, 4'h4, 24'h000003, 24'h000005, 24'h0, 8'h0, 12'h0, 4'h0, 24'hFFFFFE, 4'h9, 1'b1, 1'b1},
        '{4'h4, 4'h4, 24'h123456, 24'h123456, 24'h0, 8'h0, 12'h0, 4'h0, 24'h000000, 4'h4, 1'b1, 1'b1},
        '{4'h4, 4'h8, 24'h000001, 24'h000001, 24'h0, 8'h0, 12'h0, 4'h1, 24'h000003, 4'h0, 1'b1, 1'b1},
        '{4'h4, 4'h8, 24'h7FFFFF, 24'h000000, 24'h0, 8'h0, 12'h0, 4'h1, 24'h800000, 4'h8, 1'b1, 1'b1},
        '{4'h4, 4'hC, 24'h000005, 24'h000002, 24'h0, 8'h0, 12'h0, 4'h1, 24'h000002, 4'h0, 1'b1, 1'b1},
        '{4'h4, 4'hC, 24'h000003, 24'h000003, 24'h0, 8'h0, 12'h0, 4'h1, 24'hFFFFFF, 4'h9, 1'b1, 1'b1},
        '{4'h4, 4'h1, 24'h7FFFFF, 24'h000001, 24'h0, 8'h0, 12'h0, 4'h0, 24'h800000, 4'hA, 1'b1, 1'b1},
        '{4'h4, 4'hD, 24'h000003, 24'h000003, 24'h0, 8'h0, 12'h0, 4'h1, 24'hFFFFFF, 4'h9, 1'b1, 1'b1},
        '{4'h4, 4'h9, 24'hFFFFFF, 24'h000000, 24'h0, 8'h0, 12'h0, 4'h1, 24'h000000, 4'h5, 1'b1, 1'b1},
        '{4'h4, 4'h5, 24'h000003, 24'h000005, 24'h0, 8'h0, 12'h0, 4'h0, 24'hFFFFFE, 4'h9, 1'b1, 1'b1},
        '{4'h4, 4'h2, 24'h999999, 24'h0, 24'h000010, 8'h0, 12'hFFF, 4'hF, 24'h00000F, 4'hF, 1'b1, 1'b0},
        '{4'h4, 4'hE, 24'h999999, 24'h0, 24'h001000, 8'h0, 12'hFFF, 4'h5, 24'h000001, 4'h5, 1'b1, 1'b0},
        '{4'h4, 4'h6, 24'h999999, 24'h0, 24'h000000, 8'h0, 12'h800, 4'h0, 24'h000800, 4'h0, 1'b1, 1'b0},
        '{4'h4, 4'hA, 24'h999999, 24'h0, 24'hFFFFFF, 8'h0, 12'h001, 4'hA, 24'h000000, 4'hA, 1'b1, 1'b0},
        '{4'h4, 4'h3, 24'h000100, 24'h0, 24'hABCDEF, 8'h80, 12'h0, 4'h3, 24'h000080, 4'h3, 1'b1, 1'b0},
        '{4'h4, 4'hB, 24'h000100, 24'h0, 24'hABCDEF, 8'h80, 12'h0, 4'h0, 24'h000180, 4'h0, 1'b1, 1'b0},
        '{4'h4, 4'h7, 24'h000000, 24'h0, 24'hABCDEF, 8'hFF, 12'h0, 4'h0, 24'h000001, 4'h0, 1'b1, 1'b0},
        '{4'h4, 4'hF, 24'h000000, 24'h0, 24'hABCDEF, 8'hFF, 12'h0, 4'hC, 24'hFFFF01, 4'hC, 1'b1, 1'b0},
        '{4'h3, 4'h0, 24'h000001, 24'h000001, 24'h0, 8'h0, 12'h0, 4'h6, 24'h000002, 4'h6, 1'b0, 1'b0},
        '{4'hC, 4'h4, 24'h000005, 24'h000003, 24'h0, 8'h0, 12'h0, 4'h0, 24'h000002, 4'h0, 1'b0, 1'b0}
    };

    localparam string VTAG [NV] = '{
        "R2", "R8", "R9", "R2", "R8", "R3", "R9", "R3", "R8", "R4", "R4", "R4",
        "R4", "R5", "R5", "R5", "R10", "R6", "R6", "R6", "R6", "R1", "R1"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  major_op = '0;
    logic [3:0]  sub_op = '0;
    logic [23:0] src1_val = '0;
    logic [23:0] src2_val = '0;
    logic [23:0] dest_val = '0;
    logic [7:0]  imm8 = '0;
    logic [11:0] imm12 = '0;
    logic [3:0]  flags_in = '0;
    logic [23:0] result;
    logic        res_we;
    logic [3:0]  flags_out;
    logic        flag_we;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu24_exec u_alu24_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .major_op  (major_op),
        .sub_op    (sub_op),
        .src1_val  (src1_val),
        .src2_val  (src2_val),
        .dest_val  (dest_val),
        .imm8      (imm8),
        .imm12     (imm12),
        .flags_in  (flags_in),
        .result    (result),
        .res_we    (res_we),
        .flags_out (flags_out),
        .flag_we   (flag_we)
    );

    task automatic apply(input vec_t v);
        major_op = v.maj;
        sub_op   = v.sub;
        src1_val = v.s1;
        src2_val = v.s2;
        dest_val = v.dst;
        imm8     = v.i8;
        imm12    = v.i12;
        flags_in = v.fin;
    endtask

    task automatic compare(input string tag, input logic [23:0] er, input logic [3:0] ef,
                           input logic ew, input logic efw);
        checks++;
        if (result !== er || flags_out !== ef || res_we !== ew || flag_we !== efw) begin
            fails++;
            $display("FAIL %s: result=%h exp %h flags=%h exp %h res_we=%b exp %b flag_we=%b exp %b",
                     tag, result, er, flags_out, ef, res_we, ew, flag_we, efw);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not end, actual hung expected finished");
        finish_run();
    end

    initial begin
        // R11: outputs held at zero while reset is asserted across clock edges
        #(CLK_PERIOD * 2 + 1);
        compare("R11", 24'h0, 4'h0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table: drive at a falling edge, read one falling edge later
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            @(negedge clk);
            compare(VTAG[i], VECS[i].eres, VECS[i].eflg, VECS[i].ewe, VECS[i].efwe);
        end

        // R11: new inputs are not visible before the next rising edge
        apply(VECS[0]);
        #1;
        compare("R11", VECS[NV-1].eres, VECS[NV-1].eflg, VECS[NV-1].ewe, VECS[NV-1].efwe);
        @(negedge clk);
        compare("R11", 24'h000008, 4'h0, 1'b1, 1'b1);

        // R11: asynchronous reset clears a non-zero output at once
        apply(VECS[2]);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        compare("R11", 24'h0, 4'h0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R9", 24'h800000, 4'hA, 1'b1, 1'b1);

        finish_run();
    end

endmodule